// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Register Interface

This block is the device-side serial front end of a multi-channel sigma-delta converter. An SPI host first sends a one-byte command that names a register and a direction. The block then shifts that register's data in or out, most significant bit first. Each register has its own length. The block holds the operating-mode, configuration, GPIO-control, offset and full-scale registers. It returns a status byte and an identity byte, and it presents the most recent conversion result. That result arrives on a parallel port, which stands in for the modulator and filter.

A data-ready output goes low when a new result is latched. It returns high once that result has been fully shifted out. A mode bit appends the status byte to every data read. A streaming mode sends each new result with no fresh command. A long run of ones on the serial input brings the interface back to waiting for a command, and the registers keep their contents.

SPI timing: the host changes MOSI while SCLK is low, and the block samples MOSI on each rising SCLK edge. For reads, the first bit is on MISO before the first data rising edge. Later bits change after each falling edge. The serial inputs are sampled by `clk`, which must run at least four times faster than SCLK.

Top module: `sdadc_spi_regs`

## Requirements
- R1: A command byte is accepted only when its bit 7 is 0. Bit 6 set means read and bit 6 clear means write, and bits 5:3 give the address. A byte with bit 7 set is dropped, and the next 8 bits are taken as a new command.
- R2: The transfer length depends on the address. Addresses 0 (status), 4 (identity) and 5 (GPIO control) take 8 bits. Addresses 1 (mode), 2 (configuration), 3 (data), 6 (offset) and 7 (full-scale) take 24 bits. Data is shifted most significant bit first.
- R3: Writes to addresses 1, 2, 5, 6 and 7 update the register and its output port. A later read returns the value written. After reset each register holds its reset parameter.
- R4: Writes to addresses 0, 3 and 4 still consume their full length, but they change no register.
- R5: The status byte is laid out as follows: bit 7 equals `rdy_n`; bit 6 is the result's range error; bit 5 is the missing-reference flag; bit 4 is the XOR of the 24 result bits; bit 3 is 0; bits 2:0 are the result's channel.
- R6: When mode bit 20 is 1, a data read is 32 bits: the 24-bit result followed by the status byte.
- R7: `rdy_n` is 1 after reset. It goes low the cycle after `res_valid` latches a result. It stays low through reads of other registers, and it goes high after the last bit of a data read.
- R8: The identity register reads back as 0 in bits 7:4 and `DEV_CODE` in bits 3:0.
- R9: The read command 0x5C (address 3 with bit 2 set) starts streaming mode. In this mode each latched result is shifted out in one data-length frame, with no command needed. When no result is pending, an 8-bit frame equal to 0x58 ends streaming mode.
- R10: `ONES_LEN` consecutive 1 bits on MOSI (48 by default) return the interface to waiting for a command, and all register contents are kept.
- R11: Raising `spi_cs_n` aborts any transfer or streaming mode. A write cut short this way changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| rdy_n | output | 1 | Low while an unread result waits |
| res_valid | input | 1 | One-cycle strobe of a new conversion result |
| res_data | input | 24 | Conversion result |
| res_chan | input | 3 | Channel that produced the result |
| res_err | input | 1 | Over/under-range flag of the result |
| res_noref | input | 1 | Missing-reference flag of the result |
| mode_o | output | 24 | Mode register |
| conf_o | output | 24 | Configuration register |
| gpio_o | output | 8 | GPIO-control register |
| offset_o | output | 24 | Offset register |
| fscale_o | output | 24 | Full-scale register |

## Verification
The bench builds the block with `DEV_CODE` = 6 and leaves the other parameters at their defaults. A nonzero identity code shows whether the low nibble really comes from the parameter. The non-trivial mode and offset reset values make the reset-value reads meaningful. With `ONES_LEN` kept at 48, the bench can check that shorter runs of ones inside 24-bit data words never trigger the interface reset. It also checks that the full-length run does trigger it, both from streaming mode and from the command wait.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

  localparam int WORD_W = 24;
  localparam int BYTE_W = 8;
  localparam int FRAME_W = 32;
  localparam int APPEND_BIT = 20;

  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_MODE = 3'd1;
  localparam logic [2:0] A_CONF = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_IDEN = 3'd4;
  localparam logic [2:0] A_GPIO = 3'd5;
  localparam logic [2:0] A_OFFS = 3'd6;
  localparam logic [2:0] A_FSCL = 3'd7;

  localparam logic [7:0] STREAM_EXIT = 8'h58;

  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD, ST_STREAM} xfer_st_t;

  // number of serial bits moved for a register
  function automatic logic [5:0] reg_width(input logic [2:0] a, input logic append);
    case (a)
      A_STAT, A_IDEN, A_GPIO: reg_width = 6'd8;
      A_DATA:                 reg_width = append ? 6'd32 : 6'd24;
      default:                reg_width = 6'd24;
    endcase
  endfunction

  function automatic logic reg_writable(input logic [2:0] a);
    reg_writable = (a == A_MODE) || (a == A_CONF) || (a == A_GPIO) ||
                   (a == A_OFFS) || (a == A_FSCL);
  endfunction

  function automatic logic word_parity(input logic [WORD_W-1:0] d);
    word_parity = ^d;
  endfunction

  function automatic logic [7:0] pack_status(input logic rdy_n, input logic err,
                                             input logic noref, input logic [WORD_W-1:0] d,
                                             input logic [2:0] chan);
    pack_status = {rdy_n, err, noref, word_parity(d), 1'b0, chan};
  endfunction

  // place an n-bit value at the top of the output frame
  function automatic logic [FRAME_W-1:0] left_align(input logic [FRAME_W-1:0] w,
                                                    input logic [5:0] n);
    left_align = w << (6'd32 - n);
  endfunction

endpackage

// File: rtl/sdadc_spi_sampler.sv
module sdadc_spi_sampler #(
  parameter int ONES_LEN = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic rise_o,
  output logic fall_o,
  output logic bit_o,
  output logic idle_o,
  output logic ifr_o
);
  localparam int CW = $clog2(ONES_LEN + 1);
  localparam logic [CW-1:0] ONES_LAST = CW'(ONES_LEN - 1);
  localparam logic [CW-1:0] ONES_FULL = CW'(ONES_LEN);

  logic sclk_q, sclk_qq, cs_q, mosi_q;
  logic [CW-1:0] ones_q;

  assign rise_o = sclk_q & ~sclk_qq & ~cs_q;
  assign fall_o = ~sclk_q & sclk_qq & ~cs_q;
  assign bit_o  = mosi_q;
  assign idle_o = cs_q;
  assign ifr_o  = rise_o & mosi_q & (ones_q == ONES_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      cs_q    <= 1'b1;
      mosi_q  <= 1'b0;
      ones_q  <= '0;
    end else begin
      sclk_q  <= sclk_i;
      sclk_qq <= sclk_q;
      cs_q    <= cs_n_i;
      mosi_q  <= mosi_i;
      if (rise_o) begin
        if (!mosi_q)                ones_q <= '0;
        else if (ones_q != ONES_FULL) ones_q <= ones_q + 1'b1;
      end
    end
  end

  assert_ones_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ifr_o |=> (ones_q == ONES_FULL));

  assert_zero_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o && !mosi_q) |=> (ones_q == '0));

endmodule

// File: rtl/sdadc_regfile.sv
module sdadc_regfile
  import sdadc_pkg::*;
#(
  parameter logic [3:0]        DEV_CODE = 4'h0,
  parameter logic [WORD_W-1:0] MODE_RST = 24'h080060,
  parameter logic [WORD_W-1:0] CONF_RST = 24'h000117,
  parameter logic [WORD_W-1:0] OFFS_RST = 24'h800000,
  parameter logic [WORD_W-1:0] FSCL_RST = 24'h5A0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_addr_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic [2:0]          rd_addr_i,
  output logic [FRAME_W-1:0]  rd_word_o,
  input  logic                data_done_i,
  input  logic                res_valid_i,
  input  logic [WORD_W-1:0]   res_data_i,
  input  logic [2:0]          res_chan_i,
  input  logic                res_err_i,
  input  logic                res_noref_i,
  output logic                rdy_n_o,
  output logic                append_o,
  output logic [WORD_W-1:0]   mode_o,
  output logic [WORD_W-1:0]   conf_o,
  output logic [BYTE_W-1:0]   gpio_o,
  output logic [WORD_W-1:0]   offs_o,
  output logic [WORD_W-1:0]   fscl_o
);
  logic [WORD_W-1:0] mode_q, conf_q, offs_q, fscl_q, res_q;
  logic [BYTE_W-1:0] gpio_q;
  logic [2:0]        chan_q;
  logic              err_q, noref_q, rdy_n_q;
  logic [7:0]        status;

  assign status = pack_status(rdy_n_q, err_q, noref_q, res_q, chan_q);

  always_comb begin
    case (rd_addr_i)
      A_STAT:  rd_word_o = {24'h0, status};
      A_MODE:  rd_word_o = {8'h0, mode_q};
      A_CONF:  rd_word_o = {8'h0, conf_q};
      A_DATA:  rd_word_o = append_o ? {res_q, status} : {8'h0, res_q};
      A_IDEN:  rd_word_o = {28'h0, DEV_CODE};
      A_GPIO:  rd_word_o = {24'h0, gpio_q};
      A_OFFS:  rd_word_o = {8'h0, offs_q};
      default: rd_word_o = {8'h0, fscl_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      conf_q <= CONF_RST;
      gpio_q <= '0;
      offs_q <= OFFS_RST;
      fscl_q <= FSCL_RST;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_MODE:  mode_q <= wr_data_i;
        A_CONF:  conf_q <= wr_data_i;
        A_GPIO:  gpio_q <= wr_data_i[BYTE_W-1:0];
        A_OFFS:  offs_q <= wr_data_i;
        A_FSCL:  fscl_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      chan_q  <= '0;
      err_q   <= 1'b0;
      noref_q <= 1'b0;
      rdy_n_q <= 1'b1;
    end else if (res_valid_i) begin
      res_q   <= res_data_i;
      chan_q  <= res_chan_i;
      err_q   <= res_err_i;
      noref_q <= res_noref_i;
      rdy_n_q <= 1'b0;
    end else if (data_done_i) begin
      rdy_n_q <= 1'b1;
    end
  end

  assign rdy_n_o  = rdy_n_q;
  assign append_o = mode_q[APPEND_BIT];
  assign mode_o   = mode_q;
  assign conf_o   = conf_q;
  assign gpio_o   = gpio_q;
  assign offs_o   = offs_q;
  assign fscl_o   = fscl_q;

  assert_rdy_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_i |=> !rdy_n_o);

  assert_rdy_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done_i && !res_valid_i) |=> rdy_n_o);

  assert_ro_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !reg_writable(wr_addr_i)) |=>
      ($stable(mode_q) && $stable(conf_q) && $stable(gpio_q) &&
       $stable(offs_q) && $stable(fscl_q)));

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_i |=> $stable(res_q));

endmodule

// File: rtl/sdadc_xfer_ctrl.sv
module sdadc_xfer_ctrl
  import sdadc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               bit_i,
  input  logic               idle_i,
  input  logic               ifr_i,
  input  logic               append_i,
  input  logic               rdy_n_i,
  input  logic [FRAME_W-1:0] rd_word_i,
  output logic [2:0]         rd_addr_o,
  output logic               wr_en_o,
  output logic [2:0]         wr_addr_o,
  output logic [WORD_W-1:0]  wr_data_o,
  output logic               data_done_o,
  output logic               miso_o,
  output xfer_st_t           state_o
);
  xfer_st_t           st_q;
  logic [WORD_W-1:0]  sh_in_q;
  logic [FRAME_W-1:0] sh_out_q;
  logic [5:0]         cnt_q, width_q;
  logic [2:0]         addr_q;
  logic               is_data_q, loaded_q;

  logic [WORD_W-1:0]  in_next;
  logic [7:0]         byte_next;
  logic [5:0]         cnt_inc, cmd_width, strm_width;
  logic [2:0]         cmd_addr;
  logic               cmd_done, load_now, driving;

  assign in_next    = {sh_in_q[WORD_W-2:0], bit_i};
  assign byte_next  = in_next[7:0];
  assign cnt_inc    = cnt_q + 6'd1;
  assign cmd_addr   = byte_next[5:3];
  assign cmd_width  = reg_width(cmd_addr, append_i);
  assign strm_width = reg_width(A_DATA, append_i);
  assign cmd_done   = rise_i && (st_q == ST_CMD) && (cnt_q == 6'd7);
  assign load_now   = (st_q == ST_STREAM) && !loaded_q && !rdy_n_i && !data_done_o &&
                      (cnt_q == 6'd0) && !rise_i && !fall_i;
  assign driving    = (st_q == ST_RD) || ((st_q == ST_STREAM) && loaded_q);
  assign rd_addr_o  = (st_q == ST_STREAM) ? A_DATA : cmd_addr;
  assign miso_o     = driving & sh_out_q[FRAME_W-1];
  assign state_o    = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_CMD;
      sh_in_q     <= '0;
      sh_out_q    <= '0;
      cnt_q       <= '0;
      width_q     <= 6'd8;
      addr_q      <= '0;
      is_data_q   <= 1'b0;
      loaded_q    <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      data_done_o <= 1'b0;
    end else begin
      wr_en_o     <= 1'b0;
      data_done_o <= 1'b0;
      if (ifr_i || idle_i) begin
        st_q     <= ST_CMD;
        cnt_q    <= '0;
        loaded_q <= 1'b0;
      end else if (rise_i) begin
        sh_in_q <= in_next;
        case (st_q)
          ST_CMD: begin
            if (cnt_q == 6'd7) begin
              cnt_q <= '0;
              if (!byte_next[7]) begin
                addr_q  <= cmd_addr;
                width_q <= cmd_width;
                if (!byte_next[6]) begin
                  st_q <= ST_WR;
                end else if ((cmd_addr == A_DATA) && byte_next[2]) begin
                  st_q     <= ST_STREAM;
                  loaded_q <= 1'b0;
                end else begin
                  st_q      <= ST_RD;
                  sh_out_q  <= left_align(rd_word_i, cmd_width);
                  is_data_q <= (cmd_addr == A_DATA);
                end
              end
            end else begin
              cnt_q <= cnt_inc;
            end
          end
          ST_WR: begin
            if (cnt_inc == width_q) begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= addr_q;
              wr_data_o <= in_next;
              st_q      <= ST_CMD;
              cnt_q     <= '0;
            end else begin
              cnt_q <= cnt_inc;
            end
          end
          ST_RD: begin
            if (cnt_inc == width_q) begin
              st_q        <= ST_CMD;
              cnt_q       <= '0;
              data_done_o <= is_data_q;
            end else begin
              cnt_q <= cnt_inc;
            end
          end
          default: begin
            if ((cnt_q == 6'd7) && (byte_next == STREAM_EXIT)) begin
              st_q     <= ST_CMD;
              cnt_q    <= '0;
              loaded_q <= 1'b0;
            end else if (loaded_q && (cnt_inc == width_q)) begin
              cnt_q       <= '0;
              loaded_q    <= 1'b0;
              data_done_o <= 1'b1;
            end else if (!loaded_q && (cnt_q == 6'd7)) begin
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_inc;
            end
          end
        endcase
      end else if (fall_i) begin
        if (driving && (cnt_q != 6'd0)) sh_out_q <= sh_out_q << 1;
      end else if (load_now) begin
        sh_out_q <= left_align(rd_word_i, strm_width);
        width_q  <= strm_width;
        loaded_q <= 1'b1;
      end
    end
  end

  assert_bad_cmd_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && byte_next[7]) |=> (st_q == ST_CMD) && (cnt_q == 6'd0));

  assert_if_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ifr_i |=> (st_q == ST_CMD) && (cnt_q == 6'd0));

  assert_cs_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> (st_q == ST_CMD) && !wr_en_o);

  assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RD) || (st_q == ST_WR)) |-> (cnt_q < width_q));

  assert_stream_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_STREAM) && !loaded_q) |-> !miso_o);

endmodule

// File: rtl/sdadc_spi_regs.sv
module sdadc_spi_regs
  import sdadc_pkg::*;
#(
  parameter logic [3:0]  DEV_CODE = 4'h0,
  parameter int          ONES_LEN = 48,
  parameter logic [23:0] MODE_RST = 24'h080060,
  parameter logic [23:0] CONF_RST = 24'h000117,
  parameter logic [23:0] OFFS_RST = 24'h800000,
  parameter logic [23:0] FSCL_RST = 24'h5A0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        rdy_n,
  input  logic        res_valid,
  input  logic [23:0] res_data,
  input  logic [2:0]  res_chan,
  input  logic        res_err,
  input  logic        res_noref,
  output logic [23:0] mode_o,
  output logic [23:0] conf_o,
  output logic [7:0]  gpio_o,
  output logic [23:0] offset_o,
  output logic [23:0] fscale_o
);
  logic               rise, fall, sbit, idle, ifr;
  logic               wr_en, data_done, append;
  logic [2:0]         wr_addr, rd_addr;
  logic [WORD_W-1:0]  wr_data;
  logic [FRAME_W-1:0] rd_word;
  xfer_st_t           xstate;

  sdadc_spi_sampler #(.ONES_LEN(ONES_LEN)) u_sampler (
    .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .rise_o(rise), .fall_o(fall), .bit_o(sbit), .idle_o(idle), .ifr_o(ifr)
  );

  sdadc_xfer_ctrl u_xfer (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall), .bit_i(sbit),
    .idle_i(idle), .ifr_i(ifr), .append_i(append), .rdy_n_i(rdy_n),
    .rd_word_i(rd_word), .rd_addr_o(rd_addr), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .data_done_o(data_done), .miso_o(spi_miso), .state_o(xstate)
  );

  sdadc_regfile #(
    .DEV_CODE(DEV_CODE), .MODE_RST(MODE_RST), .CONF_RST(CONF_RST),
    .OFFS_RST(OFFS_RST), .FSCL_RST(FSCL_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_word_o(rd_word), .data_done_i(data_done),
    .res_valid_i(res_valid), .res_data_i(res_data), .res_chan_i(res_chan),
    .res_err_i(res_err), .res_noref_i(res_noref), .rdy_n_o(rdy_n), .append_o(append),
    .mode_o(mode_o), .conf_o(conf_o), .gpio_o(gpio_o), .offs_o(offset_o), .fscl_o(fscale_o)
  );

  assert_write_from_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (xstate == ST_CMD));

endmodule

// File: tb/sdadc_spi_regs_tb.sv
module sdadc_spi_regs_tb_top;

  localparam logic [3:0]  DEV    = 4'h6;
  localparam logic [23:0] M_RST  = 24'h080060;
  localparam logic [23:0] C_RST  = 24'h000117;
  localparam logic [23:0] O_RST  = 24'h800000;
  localparam logic [23:0] F_RST  = 24'h5A0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, rdy_n;
  logic res_valid = 1'b0;
  logic [23:0] res_data = '0;
  logic [2:0]  res_chan = '0;
  logic res_err = 1'b0, res_noref = 1'b0;
  logic [23:0] mode_o, conf_o, offset_o, fscale_o;
  logic [7:0]  gpio_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // bench model
  logic [23:0] mdl [8];
  logic [23:0] r_data;
  logic [2:0]  r_chan;
  logic        r_err, r_noref;

  always #2 clk = ~clk;

  sdadc_spi_regs #(.DEV_CODE(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rdy_n(rdy_n), .res_valid(res_valid),
    .res_data(res_data), .res_chan(res_chan), .res_err(res_err), .res_noref(res_noref),
    .mode_o(mode_o), .conf_o(conf_o), .gpio_o(gpio_o), .offset_o(offset_o),
    .fscale_o(fscale_o)
  );

  function automatic int exp_width(input logic [2:0] a, input logic app);
    if (a == 3'd0 || a == 3'd4 || a == 3'd5) return 8;
    if (a == 3'd3) return app ? 32 : 24;
    return 24;
  endfunction

  function automatic bit can_write(input logic [2:0] a);
    return !(a == 3'd0 || a == 3'd3 || a == 3'd4);
  endfunction

  function automatic logic [7:0] exp_status(input logic rdy);
    logic par = 1'b0;
    for (int i = 0; i < 24; i++) par = par ^ r_data[i];
    return {rdy, r_err, r_noref, par, 1'b0, r_chan};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input int n, input logic [31:0] tx, output logic [31:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = tx[i];
      tick(4);
      rx = {rx[30:0], spi_miso};
      spi_sclk = 1'b1;
      tick(4);
      spi_sclk = 1'b0;
    end
    spi_mosi = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
    logic [31:0] rx;
    spi_bits(8, {24'h0, 2'b00, a, 3'b000}, rx);
    spi_bits(exp_width(a, mdl[1][20]), v, rx);
    if (can_write(a)) mdl[a] = (a == 3'd5) ? {16'h0, v[7:0]} : v[23:0];
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
    logic [31:0] rx;
    spi_bits(8, {24'h0, 2'b01, a, 3'b000}, rx);
    spi_bits(exp_width(a, mdl[1][20]), 32'h0, v);
  endtask

  task automatic post_result(input logic [23:0] d, input logic [2:0] c,
                             input logic e, input logic n);
    res_data = d; res_chan = c; res_err = e; res_noref = n; res_valid = 1'b1;
    tick(1);
    res_valid = 1'b0;
    r_data = d; r_chan = c; r_err = e; r_noref = n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] rx;
    logic [2:0]  a;
    void'($urandom(32'd20240611));
    mdl[0] = '0; mdl[1] = M_RST; mdl[2] = C_RST; mdl[3] = '0;
    mdl[4] = '0; mdl[5] = '0; mdl[6] = O_RST; mdl[7] = F_RST;
    r_data = '0; r_chan = '0; r_err = 1'b0; r_noref = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(3);

    // reset state
    check("R7 rdy_n after reset", {31'h0, rdy_n}, 32'h1);
    check("R3 mode reset port", {8'h0, mode_o}, {8'h0, M_RST});
    check("R3 offset reset port", {8'h0, offset_o}, {8'h0, O_RST});
    spi_cs_n = 1'b0;
    tick(4);
    for (int i = 1; i < 8; i++) begin
      if (i == 3 || i == 4) continue;
      rd_reg(3'(i), v);
      check($sformatf("R3 reset read addr %0d", i), v, {8'h0, mdl[i]});
    end
    rd_reg(3'd4, v);
    check("R8 identity", v, {28'h0, DEV});
    rd_reg(3'd0, v);
    check("R5 status after reset", v, {24'h0, exp_status(1'b1)});

    // random register traffic (R2 lengths, R3 writes, R4 discards)
    for (int k = 0; k < 24; k++) begin
      a = 3'($urandom % 8);
      v = $urandom;
      if (a == 3'd1) v[20] = 1'b0;
      wr_reg(a, v);
      if (can_write(a)) begin
        rd_reg(a, rx);
        check($sformatf("R3 readback addr %0d", a), rx, {8'h0, mdl[a]});
      end else begin
        rd_reg(3'd2, rx);
        check("R4 conf kept after ro write", rx, {8'h0, mdl[2]});
        rd_reg(3'd7, rx);
        check("R4 fscale kept after ro write", rx, {8'h0, mdl[7]});
      end
      check("R3 port mode", {8'h0, mode_o}, {8'h0, mdl[1]});
      check("R3 port gpio", {24'h0, gpio_o}, {24'h0, mdl[5][7:0]});
      check("R3 port offset", {8'h0, offset_o}, {8'h0, mdl[6]});
    end

    // results, status byte and appended status
    for (int k = 0; k < 6; k++) begin
      if (k == 3) wr_reg(3'd1, {8'h0, mdl[1] | 24'h100000});
      post_result(24'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
      tick(1);
      check("R7 rdy_n low on result", {31'h0, rdy_n}, 32'h0);
      rd_reg(3'd0, v);
      check("R5 status byte", v, {24'h0, exp_status(1'b0)});
      rd_reg(3'd4, v);
      check("R7 rdy_n held after other read", {31'h0, rdy_n}, 32'h0);
      rd_reg(3'd3, v);
      if (mdl[1][20]) check("R6 data with status", v, {r_data, exp_status(1'b0)});
      else            check("R2 data 24 bit", v, {8'h0, r_data});
      tick(2);
      check("R7 rdy_n released after data read", {31'h0, rdy_n}, 32'h1);
    end
    wr_reg(3'd1, {8'h0, mdl[1] & 24'hEFFFFF});

    // R1 byte with bit 7 set is dropped
    spi_bits(8, 32'hC8, rx);
    spi_bits(8, 32'h50, rx);
    check("R1 no output after rejected byte", rx, 32'h0);
    spi_bits(24, 32'h0, rx);
    check("R1 next byte decoded as command", rx, {8'h0, mdl[2]});

    // R9 streaming
    spi_bits(8, 32'h5C, rx);
    for (int k = 0; k < 3; k++) begin
      post_result(24'($urandom), 3'(k), 1'b0, 1'b1);
      tick(12);
      spi_bits(24, 32'h0, rx);
      check("R9 streamed result", rx, {8'h0, r_data});
      tick(2);
      check("R9 rdy_n after streamed frame", {31'h0, rdy_n}, 32'h1);
    end
    spi_bits(8, 32'h58, rx);
    post_result(24'h123456, 3'd5, 1'b1, 1'b0);
    tick(12);
    rd_reg(3'd1, v);
    check("R9 command mode after exit byte", v, {8'h0, mdl[1]});
    rd_reg(3'd3, v);
    check("R9 data read after exit", v, {8'h0, 24'h123456});

    // R10 run of ones from streaming mode
    spi_bits(8, 32'h5C, rx);
    spi_bits(24, 32'hFFFFFF, rx);
    spi_bits(24, 32'hFFFFFF, rx);
    post_result(24'hABCDEF, 3'd2, 1'b0, 1'b0);
    tick(12);
    rd_reg(3'd6, v);
    check("R10 command wait after ones", v, {8'h0, mdl[6]});
    rd_reg(3'd2, v);
    check("R10 registers kept", v, {8'h0, mdl[2]});
    rd_reg(3'd3, v);
    check("R10 data after interface reset", v, {8'h0, 24'hABCDEF});

    // R11 chip select abort
    spi_bits(8, 32'h28, rx);
    spi_bits(4, 32'hA, rx);
    spi_cs_n = 1'b1;
    tick(6);
    spi_cs_n = 1'b0;
    tick(4);
    rd_reg(3'd5, v);
    check("R11 aborted write discarded", v, {24'h0, mdl[5][7:0]});
    check("R11 gpio port unchanged", {24'h0, gpio_o}, {24'h0, mdl[5][7:0]});

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule